// File: doc/BRIEF.md
# Four-Channel DMA Controller Programming Interface

This block is the host-visible side of a four-channel DMA engine in the old PC style, plus a small sequencer that performs one transfer at a time. A host reaches it over a byte-wide bus. It presents a 4-bit offset and uses separate read and write strobes. Each channel keeps a 16-bit current address and a 16-bit transfer counter. These are loaded through one byte port per register. A single shared low/high pointer picks which half each access touches. The counter holds the transfer length minus one.

When the external bus is granted, the block picks the highest-priority unmasked requesting channel. It pulses that channel's acknowledge for one cycle and presents the address. Then it steps the channel's address and counter. A channel whose counter passes zero flags terminal count. It then either masks itself or reloads its programmed start values. A channel set to cascade does no transfers. Its request is forwarded as a hold request, and the returned hold acknowledge becomes its DMA acknowledge.

Top module: `dmac4_top`

## Requirements
- R1: After reset all four channels are masked, the pointer selects the low byte, `chan_ack`, `hold_req` and `host_rdata` are 0, and the status byte reads 0x00.
- R2: Channel n's address register is at offset 2n and its counter at offset 2n+1. Each is written and read as two accesses to the same offset, low byte first then high byte. The shared pointer toggles on every read or write of offsets 0..7.
- R3: Any write to offset 0xC returns the pointer to the low byte.
- R4: A write to offset 0xA takes the channel from data bits 1:0. Data bit 2 = 1 masks it and 0 unmasks it. A masked channel never receives `chan_ack`.
- R5: A write to offset 0xE unmasks all channels. A write to offset 0xF sets the mask of channel n from data bit n.
- R6: With `bus_grant` = 1, `hold_ack` = 0 and an unmasked non-cascade channel requesting, that channel's `chan_ack` bit is 1 for exactly one cycle, starting one clock after the request. `xfer_addr` shows the address before stepping. The address then increments and the counter decrements. At least one idle cycle follows each transfer.
- R7: Mode written at offset 0xB applies to the channel in data bits 1:0. Bit 5 = 1 makes the address decrement instead of increment. Bits 3:2 appear on `xfer_dir` during the transfer.
- R8: A transfer made when the counter is 0 sets that channel's terminal-count status bit. The counter wraps to 0xFFFF and, without auto-initialise, the channel masks itself.
- R9: With mode bit 4 (auto-initialise) set, a terminal-count transfer instead restores the programmed start address and count, and the channel stays unmasked.
- R10: Reading offset 0x8 gives terminal count of channel n in bit n and a pending request of channel n in bit 4+n. The read clears bits 3:0.
- R11: Requests come from `chan_dreq` or from the software request register: a write to offset 0x9 takes the channel from bits 1:0, and bit 2 sets or clears its request. When several channels are eligible, the lowest-numbered one is served.
- R12: A channel with mode bits 7:6 = 11 does no transfers. `hold_req` is 1 one clock after such an unmasked channel's `chan_dreq` is high. While `hold_ack` is 1, that channel's `chan_ack` follows one clock later.
- R13: A write to offset 0xD masks all channels, returns the pointer to the low byte, and clears status, command and software requests. Address and counter contents are unchanged.
- R14: A command write (offset 0x8) with data bit 2 = 1 stops all transfers until it is written with bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one access per cycle high |
| host_rd | input | 1 | Read strobe, one access per cycle high |
| host_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| chan_dreq | input | 4 | Per-channel transfer request |
| chan_ack | output | 4 | Per-channel acknowledge |
| bus_grant | input | 1 | External bus available for a transfer |
| hold_req | output | 1 | Forwarded request from cascade channels |
| hold_ack | input | 1 | Acknowledge returned for cascade channels |
| xfer_addr | output | 16 | Address of the transfer being acknowledged |
| xfer_dir | output | 2 | Direction field of the transferring channel |

## Verification
Directed transfers are run with two channels requesting at once, with a software request against a pin request, and with the mask, mask-all and command-disable controls toggled. These separate a priority fault from a masking fault. Randomly placed programs run one channel to terminal count over all four combinations of increment/decrement and auto-initialise. They compare every acknowledged address, the status byte and the wrapped counter. This separates a stepping fault from a reload or self-mask fault. Byte-pointer runs that are interrupted by a pointer clear or a master clear show whether the pointer, rather than the data, was disturbed.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  // mode byte bits 7:2 (bits 1:0 select the channel)
  typedef struct packed {
    logic [1:0] kind;      // 01 single, 11 cascade
    logic       dec;       // address steps downward
    logic       autoinit;  // reload on terminal count
    logic [1:0] dir;       // transfer direction code
  } chan_mode_t;

  localparam logic [1:0] KIND_CASCADE = 2'b11;

  localparam logic [3:0] OFS_CMD     = 4'h8;
  localparam logic [3:0] OFS_SWREQ   = 4'h9;
  localparam logic [3:0] OFS_MASK1   = 4'hA;
  localparam logic [3:0] OFS_MODE    = 4'hB;
  localparam logic [3:0] OFS_PTRCLR  = 4'hC;
  localparam logic [3:0] OFS_MCLR    = 4'hD;
  localparam logic [3:0] OFS_UNMASK  = 4'hE;
  localparam logic [3:0] OFS_MASKALL = 4'hF;

endpackage

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win
);
  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 2 * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_addr,
  input  logic                 ld_cnt,
  input  logic                 ld_hi,
  input  logic [BYTE_W-1:0]    wbyte,
  input  logic                 mode_we,
  input  dmac_pkg::chan_mode_t mode_in,
  input  logic                 step,
  output logic [REG_W-1:0]     cur_addr,
  output logic [REG_W-1:0]     cur_cnt,
  output dmac_pkg::chan_mode_t mode,
  output logic                 tc_hit
);
  logic [REG_W-1:0] base_addr, base_cnt;

  assign tc_hit = step && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
    end else begin
      if (mode_we) mode <= mode_in;

      // host loads take precedence over a transfer step
      if (ld_addr) begin
        if (ld_hi) begin
          base_addr[REG_W-1:BYTE_W] <= wbyte;
          cur_addr[REG_W-1:BYTE_W]  <= wbyte;
        end else begin
          base_addr[BYTE_W-1:0] <= wbyte;
          cur_addr[BYTE_W-1:0]  <= wbyte;
        end
      end else if (step) begin
        if (tc_hit && mode.autoinit) cur_addr <= base_addr;
        else if (mode.dec)           cur_addr <= cur_addr - 1'b1;
        else                         cur_addr <= cur_addr + 1'b1;
      end

      if (ld_cnt) begin
        if (ld_hi) begin
          base_cnt[REG_W-1:BYTE_W] <= wbyte;
          cur_cnt[REG_W-1:BYTE_W]  <= wbyte;
        end else begin
          base_cnt[BYTE_W-1:0] <= wbyte;
          cur_cnt[BYTE_W-1:0]  <= wbyte;
        end
      end else if (step) begin
        if (tc_hit && mode.autoinit) cur_cnt <= base_cnt;
        else                         cur_cnt <= cur_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmac4_top.sv
module dmac4_top #(
  parameter int NCH    = 4,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            host_addr,
  input  logic [BYTE_W-1:0]     host_wdata,
  input  logic                  host_wr,
  input  logic                  host_rd,
  output logic [BYTE_W-1:0]     host_rdata,
  input  logic [NCH-1:0]        chan_dreq,
  output logic [NCH-1:0]        chan_ack,
  input  logic                  bus_grant,
  output logic                  hold_req,
  input  logic                  hold_ack,
  output logic [2*BYTE_W-1:0]   xfer_addr,
  output logic [1:0]            xfer_dir
);
  import dmac_pkg::*;

  localparam int REG_W = 2 * BYTE_W;
  localparam int SEL_W = $clog2(NCH);

  logic                 ff_q, cmd_off_q, busy_q, hold_req_q, mclr;
  logic [NCH-1:0]       mask_q, mask_d, swreq_q, swreq_d, tc_q, tc_d;
  logic [NCH-1:0]       tc_set, ai_vec, casc_vec, go_vec, req_raw;
  logic [NCH-1:0]       single_el, casc_el, single_win, casc_win, ack_q;
  logic [REG_W-1:0]     addr_arr [NCH];
  logic [REG_W-1:0]     cnt_arr  [NCH];
  chan_mode_t           mode_arr [NCH];
  logic [REG_W-1:0]     sel_addr, rd_word, xfer_addr_q;
  logic [1:0]           sel_dir, xfer_dir_q;
  logic [BYTE_W-1:0]    rd_value, rdata_q;
  logic                 wr_chreg, rd_chreg, rd_status, can_go;
  logic [SEL_W-1:0]     reg_sel, data_sel;

  // ---------------- host decode ----------------
  assign reg_sel   = host_addr[SEL_W:1];
  assign data_sel  = host_wdata[SEL_W-1:0];
  assign wr_chreg  = host_wr && !host_addr[3];
  assign rd_chreg  = host_rd && !host_wr && !host_addr[3];
  assign rd_status = host_rd && !host_wr && (host_addr == OFS_CMD);
  assign mclr      = host_wr && (host_addr == OFS_MCLR);

  // ---------------- channels ----------------
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dmac_chan #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .ld_addr  (wr_chreg && (reg_sel == SEL_W'(i)) && !host_addr[0]),
      .ld_cnt   (wr_chreg && (reg_sel == SEL_W'(i)) &&  host_addr[0]),
      .ld_hi    (ff_q),
      .wbyte    (host_wdata),
      .mode_we  (host_wr && (host_addr == OFS_MODE) && (data_sel == SEL_W'(i))),
      .mode_in  (chan_mode_t'(host_wdata[7:2])),
      .step     (go_vec[i]),
      .cur_addr (addr_arr[i]),
      .cur_cnt  (cnt_arr[i]),
      .mode     (mode_arr[i]),
      .tc_hit   (tc_set[i])
    );
    assign ai_vec[i]   = mode_arr[i].autoinit;
    assign casc_vec[i] = (mode_arr[i].kind == KIND_CASCADE);
  end

  // ---------------- request selection ----------------
  assign req_raw   = chan_dreq | swreq_q;
  assign single_el = req_raw & ~mask_q & ~casc_vec;
  assign casc_el   = chan_dreq & ~mask_q & casc_vec;
  assign can_go    = bus_grant && !hold_ack && !cmd_off_q && !busy_q;
  assign go_vec    = can_go ? single_win : '0;

  dmac_prio #(.N(NCH)) u_prio_single (.req(single_el), .win(single_win));
  dmac_prio #(.N(NCH)) u_prio_casc   (.req(casc_el),   .win(casc_win));

  always_comb begin
    sel_addr = '0;
    sel_dir  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (go_vec[i]) begin
        sel_addr = addr_arr[i];
        sel_dir  = mode_arr[i].dir;
      end
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_word  = host_addr[0] ? cnt_arr[reg_sel] : addr_arr[reg_sel];
    rd_value = '0;
    if (!host_addr[3])
      rd_value = ff_q ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    else if (host_addr == OFS_CMD)
      rd_value = BYTE_W'({req_raw, tc_q});
  end

  // ---------------- control state next values ----------------
  always_comb begin
    mask_d  = mask_q;
    swreq_d = swreq_q;
    tc_d    = tc_q;
    if (host_wr) begin
      case (host_addr)
        OFS_SWREQ:   swreq_d[data_sel] = host_wdata[2];
        OFS_MASK1:   mask_d[data_sel]  = host_wdata[2];
        OFS_UNMASK:  mask_d = '0;
        OFS_MASKALL: mask_d = host_wdata[NCH-1:0];
        OFS_MCLR: begin
          mask_d  = '1;
          swreq_d = '0;
          tc_d    = '0;
        end
        default: ;
      endcase
    end
    if (rd_status) tc_d = '0;
    tc_d    = tc_d | tc_set;
    mask_d  = mask_d | (tc_set & ~ai_vec);
    swreq_d = swreq_d & ~tc_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '1;
      swreq_q     <= '0;
      tc_q        <= '0;
      ff_q        <= 1'b0;
      cmd_off_q   <= 1'b0;
      busy_q      <= 1'b0;
      ack_q       <= '0;
      hold_req_q  <= 1'b0;
      xfer_addr_q <= '0;
      xfer_dir_q  <= '0;
      rdata_q     <= '0;
    end else begin
      mask_q  <= mask_d;
      swreq_q <= swreq_d;
      tc_q    <= tc_d;

      if (mclr || (host_wr && host_addr == OFS_PTRCLR)) ff_q <= 1'b0;
      else if (wr_chreg || rd_chreg)                    ff_q <= ~ff_q;

      if (mclr)                                  cmd_off_q <= 1'b0;
      else if (host_wr && host_addr == OFS_CMD)  cmd_off_q <= host_wdata[2];

      busy_q     <= |go_vec;
      ack_q      <= go_vec | (hold_ack ? casc_win : '0);
      hold_req_q <= |casc_el;

      if (|go_vec) begin
        xfer_addr_q <= sel_addr;
        xfer_dir_q  <= sel_dir;
      end

      rdata_q <= (host_rd && !host_wr) ? rd_value : '0;
    end
  end

  assign host_rdata = rdata_q;
  assign chan_ack   = ack_q;
  assign hold_req   = hold_req_q;
  assign xfer_addr  = xfer_addr_q;
  assign xfer_dir   = xfer_dir_q;

endmodule

// File: rtl/dmac4_sva.sv
module dmac4_sva #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           host_wr,
  input logic [3:0]     host_addr,
  input logic           hold_ack,
  input logic [NCH-1:0] chan_ack,
  input logic [NCH-1:0] mask_q,
  input logic           cmd_off_q,
  input logic           ff_q,
  input logic [NCH-1:0] tc_set,
  input logic [NCH-1:0] ai_vec
);
  // R6: never more than one channel acknowledged
  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_ack));

  // R4: acknowledge only goes to a channel unmasked the cycle before
  p_ack_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
    (|chan_ack) |-> ((chan_ack & $past(mask_q)) == '0));

  // R3: pointer clear write leaves pointer on low byte
  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 4'hC) |=> !ff_q);

  // R8: terminal count without auto-initialise masks the channel
  p_tc_masks_r8: assert property (@(posedge clk) disable iff (rst)
    (|(tc_set & ~ai_vec)) |=> (($past(tc_set & ~ai_vec) & ~mask_q) == '0));

  // R14: command disable blocks all transfer acknowledges
  p_cmd_off_r14: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_off_q) && !$past(hold_ack)) |-> (chan_ack == '0));
endmodule

bind dmac4_top dmac4_sva #(.NCH(NCH)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .hold_ack  (hold_ack),
  .chan_ack  (chan_ack),
  .mask_q    (mask_q),
  .cmd_off_q (cmd_off_q),
  .ff_q      (ff_q),
  .tc_set    (tc_set),
  .ai_vec    (ai_vec)
);

// File: tb/dmac4_top_tb.sv
`timescale 1ns/1ps
module dmac4_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic [3:0]  chan_dreq = '0;
  logic [3:0]  chan_ack;
  logic        bus_grant = 1'b0, hold_ack = 1'b0;
  logic        hold_req;
  logic [15:0] xfer_addr;
  logic [1:0]  xfer_dir;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dmac4_top dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .chan_dreq(chan_dreq), .chan_ack(chan_ack), .bus_grant(bus_grant),
    .hold_req(hold_req), .hold_ack(hold_ack), .xfer_addr(xfer_addr),
    .xfer_dir(xfer_dir)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  // one grant cycle; check acknowledge and address one clock later
  task automatic xfer(input string tag, input logic [3:0] req,
                      input logic [3:0] exp_ack, input logic [15:0] exp_addr);
    @(negedge clk); chan_dreq = req; bus_grant = 1'b1;
    @(negedge clk); chan_dreq = '0;  bus_grant = 1'b0;
    chk(tag, chan_ack, exp_ack);
    if (exp_ack != 0) chk(tag, xfer_addr, exp_addr);
    @(negedge clk);
    chk(tag, chan_ack, 0);
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c,
                      input logic [7:0] mode);
    wr(4'hC, 0);
    wr(4'(2*ch), a[7:0]);   wr(4'(2*ch), a[15:8]);
    wr(4'(2*ch+1), c[7:0]); wr(4'(2*ch+1), c[15:8]);
    wr(4'hB, mode | 8'(ch));
    wr(4'hA, 8'(ch));
  endtask

  function automatic logic [15:0] step_addr(logic [15:0] a, bit dec, int k);
    return dec ? a - 16'(k) : a + 16'(k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", host_rdata, 0);
    chk("R1 ack", chan_ack, 0);
    chk("R1 hold_req", hold_req, 0);
    rd(4'h8, d); chk("R1 status", d, 0);
    xfer("R1 masked at reset", 4'b0001, 4'b0000, 0);

    // R2 byte-pair access
    wr(4'hD, 0);
    prog(2, 16'h1234, 16'hABCD, 8'h44);
    rd(4'h4, d); chk("R2 addr lo", d, 8'h34);
    rd(4'h4, d); chk("R2 addr hi", d, 8'h12);
    rd(4'h5, d); chk("R2 cnt lo", d, 8'hCD);
    rd(4'h5, d); chk("R2 cnt hi", d, 8'hAB);

    // R3 pointer clear
    wr(4'hD, 0);
    wr(4'h2, 8'h55); wr(4'hC, 0);
    wr(4'h2, 8'h66); wr(4'h2, 8'h77); wr(4'hC, 0);
    rd(4'h2, d); chk("R3 lo after clear", d, 8'h66);
    rd(4'h2, d); chk("R3 hi after clear", d, 8'h77);

    // R11 priority and software request, R10 pending bits, R7 direction
    wr(4'hD, 0);
    prog(1, 16'h0100, 16'd9, 8'h48);
    prog(3, 16'h0300, 16'd9, 8'h44);
    xfer("R11 ch1 over ch3", 4'b1010, 4'b0010, 16'h0100);
    chk("R7 dir field", xfer_dir, 2'b10);
    prog(0, 16'h0000, 16'd9, 8'h44);
    wr(4'h9, 8'h04);
    rd(4'h8, d); chk("R10 pending from sw request", d, 8'h10);
    xfer("R11 sw request ch0 wins", 4'b1010, 4'b0001, 16'h0000);
    wr(4'h9, 8'h00);
    xfer("R11 ch3 alone", 4'b1000, 4'b1000, 16'h0300);

    // R5 mask all / clear all, R4 single mask
    wr(4'hF, 8'h0F);
    xfer("R5 mask all", 4'b1000, 4'b0000, 0);
    wr(4'hE, 0);
    xfer("R5 unmask all", 4'b1000, 4'b1000, 16'h0301);
    wr(4'hA, 8'h07);
    xfer("R4 single mask", 4'b1000, 4'b0000, 0);
    wr(4'hA, 8'h03);
    xfer("R4 single unmask", 4'b1000, 4'b1000, 16'h0302);

    // R14 command disable
    wr(4'h8, 8'h04);
    xfer("R14 disabled", 4'b1000, 4'b0000, 0);
    wr(4'h8, 8'h00);
    xfer("R14 re-enabled", 4'b1000, 4'b1000, 16'h0303);

    // R12 cascade passthrough
    wr(4'hD, 0);
    wr(4'hB, 8'hC3); wr(4'hA, 8'h03);
    @(negedge clk); chan_dreq = 4'b1000; bus_grant = 1'b1;
    @(negedge clk);
    chk("R12 hold_req", hold_req, 1);
    chk("R12 no transfer", chan_ack, 0);
    hold_ack = 1'b1;
    @(negedge clk);
    chk("R12 ack from hold_ack", chan_ack, 4'b1000);
    hold_ack = 1'b0; chan_dreq = '0; bus_grant = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 hold_req drop", hold_req, 0);
    chk("R12 ack drop", chan_ack, 0);

    // R13 master clear
    wr(4'hD, 0);
    prog(2, 16'h1234, 16'd5, 8'h44);
    wr(4'h5, 8'h99);
    wr(4'hD, 0);
    rd(4'h4, d); chk("R13 ptr cleared, addr kept lo", d, 8'h34);
    rd(4'h4, d); chk("R13 addr kept hi", d, 8'h12);
    xfer("R13 masks set", 4'b0100, 4'b0000, 0);

    // random programs to terminal count: R6 R7 R8 R9 R10
    for (int it = 0; it < 24; it++) begin
      int ch, n;
      bit dec, ai;
      logic [15:0] a;
      ch  = int'($urandom % 4);
      n   = int'($urandom % 4) + 1;
      a   = 16'($urandom);
      dec = it[0];
      ai  = it[1];
      wr(4'hD, 0);
      prog(ch, a, 16'(n - 1), 8'h44 | (8'(dec) << 5) | (8'(ai) << 4));
      for (int k = 0; k < n; k++)
        xfer(dec ? "R7 decrement transfer" : "R6 increment transfer",
             4'(1 << ch), 4'(1 << ch), step_addr(a, dec, k));
      rd(4'h8, d); chk("R8 tc status bit", d, 8'(1 << ch));
      rd(4'h8, d); chk("R10 status read clears tc", d, 0);
      if (ai) begin
        xfer("R9 reload, still unmasked", 4'(1 << ch), 4'(1 << ch), a);
      end else begin
        xfer("R8 self-masked", 4'(1 << ch), 4'b0000, 0);
        wr(4'hC, 0);
        rd(4'(2*ch+1), d); rd(4'(2*ch+1), d2);
        chk("R8 count wrapped", {d2, d}, 16'hFFFF);
        chk("R8 remaining wraps to 0", 16'({d2, d} + 16'd1), 0);
        rd(4'(2*ch), d); rd(4'(2*ch), d2);
        chk("R6 final address", {d2, d}, step_addr(a, dec, n));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule